// File: doc/BRIEF.md
# Encrypted Region Access Policy Checker

This block sits in front of an on-the-fly cipher that serves reads from an external memory window. It keeps four address regions, each with inclusive lower and upper bounds, an enable, a two-bit mode and an 8-bit key checksum. For every read request it decides whether the cipher's plaintext may be returned or whether the read data must be forced to zero. It also raises single-cycle error events when an access type is not allowed or when a key is not usable. The cipher and the register file are outside this block: region settings arrive as static inputs, and a global encryption-mode bit comes in from the control logic.

Each request is accepted on the clock edge where `req_valid` is high. The verdict appears on the `rsp_*` outputs for exactly one cycle after that edge. Every region remembers a key error. Once a read has hit a region whose checksum was zero, that region keeps forcing zeros until a non-zero checksum has been seen at a clock edge.

Top module: `region_access_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every `rsp_*` output is 0. Reset also clears the key-error memory of every region.
- R2: A request hits region i when `cfg_en[i]` is 1 and `cfg_lo[i] <= req_addr <= cfg_hi[i]`, with both bounds included. When several regions hit, the lowest index wins and is reported on `rsp_region`. A disabled region never hits, and `rsp_region` is 0 on a miss.
- R3: A request that hits no region gives `rsp_hit`=0, `rsp_decrypt`=0, `rsp_zero`=0 and no error pulse, unless R6 applies.
- R4: Mode 2'b10 allows decryption of both instruction fetches (`req_is_fetch`=1) and data reads. `rsp_decrypt` and `rsp_zero` are never 1 together.
- R5: Mode 2'b11 decrypts instruction fetches only. A data read that hits such a region gives `rsp_zero`=1 and a pulse on `rsp_xo_err`.
- R6: While `enc_mode_on` is 1, every instruction fetch gives `rsp_zero`=1, `rsp_decrypt`=0 and a pulse on `rsp_xo_err`, whether it hits a region or not. Data reads follow the region rules.
- R7: The reserved modes 2'b00 and 2'b01 force zero on a hit, with no decryption and no error pulse.
- R8: A read that hits a region whose checksum `cfg_ksum[i]` is 8'h00 gives `rsp_zero`=1 and a pulse on `rsp_key_err`. This pulse can come in the same cycle as an `rsp_xo_err` pulse.
- R9: After a key error in region i, reads of region i return zero without a key-error pulse until `cfg_ksum[i]` has been non-zero at a clock edge. A read accepted at the very first edge where the checksum is non-zero is still zeroed. The read after it is decrypted normally.
- R10: `rsp_valid` is 1 in exactly the cycle after each accepted request. Error pulses last one cycle, and with no request all `rsp_*` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_mode_on | input | 1 | Global encryption mode |
| cfg_en | input | NUM_RGN | Region enables |
| cfg_mode | input | NUM_RGN x 2 | Region modes |
| cfg_lo | input | NUM_RGN x ADDR_W | Inclusive lower bounds |
| cfg_hi | input | NUM_RGN x ADDR_W | Inclusive upper bounds |
| cfg_ksum | input | NUM_RGN x KSUM_W | Key checksums; zero means the key is invalid |
| req_valid | input | 1 | Request accepted on this edge |
| req_addr | input | ADDR_W | Request address |
| req_is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data read |
| rsp_valid | output | 1 | Verdict valid |
| rsp_hit | output | 1 | Some enabled region matched |
| rsp_region | output | IDX_W | Index of the winning region |
| rsp_decrypt | output | 1 | Decrypted data may be returned |
| rsp_zero | output | 1 | Data must be forced to zero |
| rsp_xo_err | output | 1 | Access-type violation pulse |
| rsp_key_err | output | 1 | Key error pulse |

## Verification
The access-type violation and the key error can fire in the same verdict. The bench provokes this in two ways: a data read into a fetch-only region whose checksum is zero, and an instruction fetch under encryption mode that hits the zero-key region. It then expects both pulses high together with `rsp_zero` and no decryption. A second collision is between the key-error memory and a key reload. The checksum becomes non-zero at the same edge that accepts a read. That read must still be zeroed without a pulse, and the next read must be decrypted.

// File: rtl/rag_pkg.sv
package rag_pkg;

  typedef enum logic [1:0] {
    MODE_RSV0       = 2'b00,
    MODE_RSV1       = 2'b01,
    MODE_ALL        = 2'b10,
    MODE_FETCH_ONLY = 2'b11
  } rgn_mode_e;

  typedef struct packed {
    logic hit;
    logic dec;
    logic zero;
    logic xo;
    logic ke;
  } verdict_t;

endpackage

// File: rtl/rag_range_cmp.sv
module rag_range_cmp #(
  parameter int ADDR_W  = 32,
  parameter int NUM_RGN = 4
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_RGN-1:0]              en,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0]  lo,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0]  hi,
  output logic [NUM_RGN-1:0]              match
);

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic above_lo;
    logic below_hi;
    assign above_lo = (addr >= lo[g]);
    assign below_hi = (addr <= hi[g]);
    assign match[g] = en[g] & above_lo & below_hi;
  end

endmodule

// File: rtl/rag_first_hit.sv
module rag_first_hit #(
  parameter int NUM_RGN = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_RGN-1:0] vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = i[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/rag_key_track.sv
module rag_key_track #(
  parameter int NUM_RGN = 4,
  parameter int KSUM_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_RGN-1:0][KSUM_W-1:0]  ksum,
  input  logic [NUM_RGN-1:0]              err_set,
  output logic [NUM_RGN-1:0]              key_bad,
  output logic [NUM_RGN-1:0]              sticky
);

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_trk
    logic sticky_q;
    logic sticky_d;
    logic sticky_en;

    assign key_bad[g] = (ksum[g] == '0);

    // the flag loads on a new key error or on a usable checksum
    always_comb begin
      sticky_en = err_set[g] | ~key_bad[g];
      sticky_d  = err_set[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sticky_q <= 1'b0;
      else if (sticky_en) sticky_q <= sticky_d;
    end

    assign sticky[g] = sticky_q;
  end

endmodule

// File: rtl/region_access_guard.sv
module region_access_guard
  import rag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_RGN = 4,
  parameter int KSUM_W  = 8,
  localparam int IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enc_mode_on,
  input  logic [NUM_RGN-1:0]              cfg_en,
  input  logic [NUM_RGN-1:0][1:0]         cfg_mode,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0]  cfg_lo,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0]  cfg_hi,
  input  logic [NUM_RGN-1:0][KSUM_W-1:0]  cfg_ksum,
  input  logic                            req_valid,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic                            req_is_fetch,
  output logic                            rsp_valid,
  output logic                            rsp_hit,
  output logic [IDX_W-1:0]                rsp_region,
  output logic                            rsp_decrypt,
  output logic                            rsp_zero,
  output logic                            rsp_xo_err,
  output logic                            rsp_key_err
);

  logic [NUM_RGN-1:0] match;
  logic               any_hit;
  logic [IDX_W-1:0]   pick;
  logic [NUM_RGN-1:0] key_bad;
  logic [NUM_RGN-1:0] sticky;
  logic [NUM_RGN-1:0] err_set;

  rag_range_cmp #(.ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN)) u_cmp (
    .addr  (req_addr),
    .en    (cfg_en),
    .lo    (cfg_lo),
    .hi    (cfg_hi),
    .match (match)
  );

  rag_first_hit #(.NUM_RGN(NUM_RGN), .IDX_W(IDX_W)) u_pick (
    .vec (match),
    .any (any_hit),
    .idx (pick)
  );

  rag_key_track #(.NUM_RGN(NUM_RGN), .KSUM_W(KSUM_W)) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .ksum    (cfg_ksum),
    .err_set (err_set),
    .key_bad (key_bad),
    .sticky  (sticky)
  );

  // ---------------- policy decision ----------------
  rgn_mode_e sel_mode;
  logic      sel_bad;
  logic      sel_sticky;
  logic      fetch_blocked;
  logic      mode_allows;
  verdict_t  vrd;

  always_comb begin
    sel_mode      = rgn_mode_e'(cfg_mode[pick]);
    sel_bad       = key_bad[pick];
    sel_sticky    = sticky[pick];
    fetch_blocked = enc_mode_on & req_is_fetch;

    unique case (sel_mode)
      MODE_ALL:        mode_allows = 1'b1;
      MODE_FETCH_ONLY: mode_allows = req_is_fetch;
      default:         mode_allows = 1'b0;
    endcase

    vrd.hit  = any_hit;
    vrd.xo   = fetch_blocked |
               (any_hit & (sel_mode == MODE_FETCH_ONLY) & ~req_is_fetch);
    vrd.ke   = any_hit & sel_bad;
    vrd.zero = fetch_blocked |
               (any_hit & (~mode_allows | sel_bad | sel_sticky));
    vrd.dec  = any_hit & mode_allows & ~fetch_blocked & ~sel_bad & ~sel_sticky;
  end

  always_comb begin
    err_set = '0;
    if (req_valid && vrd.ke) err_set[pick] = 1'b1;
  end

  // ---------------- response stage ----------------
  logic             valid_d, valid_q;
  verdict_t         vrd_d, vrd_q;
  logic [IDX_W-1:0] idx_d, idx_q;

  always_comb begin
    valid_d = req_valid;
    vrd_d   = req_valid ? vrd : '0;
    idx_d   = (req_valid && any_hit) ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vrd_q   <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      vrd_q   <= vrd_d;
      idx_q   <= idx_d;
    end
  end

  assign rsp_valid   = valid_q;
  assign rsp_hit     = vrd_q.hit;
  assign rsp_region  = idx_q;
  assign rsp_decrypt = vrd_q.dec;
  assign rsp_zero    = vrd_q.zero;
  assign rsp_xo_err  = vrd_q.xo;
  assign rsp_key_err = vrd_q.ke;

endmodule

// File: rtl/rag_checker.sv
module rag_checker #(
  parameter int NUM_RGN = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enc_mode_on,
  input logic [NUM_RGN-1:0] cfg_en,
  input logic               req_valid,
  input logic               req_is_fetch,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_decrypt,
  input logic               rsp_zero,
  input logic               rsp_xo_err,
  input logic               rsp_key_err
);

  // R10: a verdict follows each accepted request
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10: silence after an idle cycle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_decrypt && !rsp_zero &&
                    !rsp_xo_err && !rsp_key_err));

  // R6: fetches blocked in encryption mode
  a_r6_fetch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enc_mode_on && req_is_fetch) |=>
      (rsp_xo_err && rsp_zero && !rsp_decrypt));

  // R2: no region can hit while all are disabled
  a_r2_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_en == '0) |=> !rsp_hit);

  // R8: key error always zeroes a hit
  a_r8_key_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_key_err |-> (rsp_zero && rsp_hit && !rsp_decrypt));

  // R5: access violation always zeroes
  a_r5_xo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_xo_err |-> (rsp_zero && !rsp_decrypt));

  // R4: decrypt and zero are exclusive
  a_r4_dec_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_decrypt |-> (!rsp_zero && rsp_hit));

  // R3: a miss without violation is plain pass-through
  a_r3_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !rsp_xo_err) |-> (!rsp_zero && !rsp_key_err));

endmodule

bind region_access_guard rag_checker #(.NUM_RGN(NUM_RGN)) u_chk (.*);

// File: tb/sim_region_access_guard.sv
module sim_region_access_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int AW = 32;
  localparam int KW = 8;

  logic                    clk;
  logic                    rst_n;
  logic                    enc_mode_on;
  logic [NR-1:0]           cfg_en;
  logic [NR-1:0][1:0]      cfg_mode;
  logic [NR-1:0][AW-1:0]   cfg_lo;
  logic [NR-1:0][AW-1:0]   cfg_hi;
  logic [NR-1:0][KW-1:0]   cfg_ksum;
  logic                    req_valid;
  logic [AW-1:0]           req_addr;
  logic                    req_is_fetch;
  logic                    rsp_valid, rsp_hit, rsp_decrypt, rsp_zero;
  logic                    rsp_xo_err, rsp_key_err;
  logic [1:0]              rsp_region;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  region_access_guard #(.ADDR_W(AW), .NUM_RGN(NR), .KSUM_W(KW)) u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic        fetch;
    logic        enc;
    logic        hit;
    logic [1:0]  idx;
    logic        dec;
    logic        zero;
    logic        xo;
    logic        ke;
  } vec_t;

  // regions: r0 [1000,1FFF] mode 10 ok; r1 [1800,2FFF] mode 11 ok;
  // r2 [4000,4FFF] mode 10 checksum 0; r3 [6000,6FFF] disabled
  localparam vec_t VECS [12] = '{
    '{32'h0000_1000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 low bound, R4 data
    '{32'h0000_1FFF, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 high bound + overlap, R4 fetch
    '{32'h0000_2000, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 fetch ok
    '{32'h0000_2FFF, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 data blocked
    '{32'h0000_3000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 miss
    '{32'h0000_0FFF, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 below r0
    '{32'h0000_6000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 disabled
    '{32'h0000_4000, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 bad key
    '{32'h0000_1000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 hit fetch
    '{32'h0000_5000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 miss fetch
    '{32'h0000_1000, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 data allowed
    '{32'h0000_4800, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1}  // R8 with xo
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives, waits one edge, checks at next negedge
  task automatic issue(input vec_t v, input string tag);
    req_valid    = 1'b1;
    req_addr     = v.addr;
    req_is_fetch = v.fetch;
    enc_mode_on  = v.enc;
    @(negedge clk);
    chk({tag, " valid"},  32'(rsp_valid),   32'd1);
    chk({tag, " hit"},    32'(rsp_hit),     32'(v.hit));
    chk({tag, " region"}, 32'(rsp_region),  32'(v.idx));
    chk({tag, " dec"},    32'(rsp_decrypt), 32'(v.dec));
    chk({tag, " zero"},   32'(rsp_zero),    32'(v.zero));
    chk({tag, " xo"},     32'(rsp_xo_err),  32'(v.xo));
    chk({tag, " ke"},     32'(rsp_key_err), 32'(v.ke));
    req_valid = 1'b0;
  endtask

  task automatic check_quiet(input string tag);
    chk({tag, " valid"}, 32'(rsp_valid),   32'd0);
    chk({tag, " out"},   32'({rsp_hit, rsp_decrypt, rsp_zero, rsp_xo_err,
                              rsp_key_err, rsp_region}), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_is_fetch = 1'b0; enc_mode_on = 1'b0;
    cfg_en = 4'b0111;
    cfg_mode = '{2'b10, 2'b10, 2'b11, 2'b10};   // index 3..0
    cfg_lo   = '{32'h6000, 32'h4000, 32'h1800, 32'h1000};
    cfg_hi   = '{32'h6FFF, 32'h4FFF, 32'h2FFF, 32'h1FFF};
    cfg_ksum = '{8'h11, 8'h00, 8'h3C, 8'hA5};
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 after release");

    for (int i = 0; i < 12; i++) issue(VECS[i], $sformatf("table[%0d]", i));

    // R10: idle cycle after a violation pulse
    @(negedge clk);
    check_quiet("R10 idle");

    // R9: checksum goes non-zero at the edge that accepts the read
    cfg_ksum[2] = 8'h77;
    issue('{32'h4000, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0}, "R9 same edge");
    issue('{32'h4000, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0}, "R9 reloaded");

    // R7: reserved modes
    cfg_mode[0] = 2'b01;
    issue('{32'h1000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0}, "R7 mode01");
    cfg_mode[0] = 2'b00;
    issue('{32'h1000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0}, "R7 mode00");
    cfg_mode[0] = 2'b10;

    // R8 with R5: data read to fetch-only region with zero checksum
    cfg_ksum[1] = 8'h00;
    issue('{32'h2100, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1}, "R8+R5 same cycle");

    // R1: reset clears key-error memory; checksum restored during reset
    rst_n = 1'b0;
    cfg_ksum[1] = 8'h3C;
    @(negedge clk);
    check_quiet("R1 mid reset");
    rst_n = 1'b1;
    issue('{32'h2000, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0}, "R1 after reset");

    @(negedge clk);
    check_quiet("R10 final idle");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule